// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator

This block compares a divided oscillator signal against a reference clock and tells a charge pump which way to push. When the divided signal's rising edge comes first, the outputs drive high. When the reference edge comes first, they drive low. When neither is pending, the outputs float. A pending request is cleared at the next edge of the other signal. Both inputs are sampled in the system clock domain, and rising edges are found by comparing each input with its value from the previous cycle.

Two outputs carry the comparator result side by side, so that separate loop filters can be tuned for different bands. The second output has its own 2-bit mode control. In one mode it follows the comparator. Other modes float it or turn it into a plain output port driven from a register bit. Software can use this to change loop bandwidth during acquisition. Each pin is modelled as a drive-enable and value pair instead of a real tri-state net.

Top module: `pfd_tristate`

## Requirements
- R1: After reset with mode 00 and both inputs low, both outputs are high impedance (enable 0).
- R2: When the outputs are idle and a rising edge of `div_i` is sampled without a rising edge of `ref_i` in the same cycle, output 1 drives high (enable 1, value 1) from the next cycle.
- R3: When the outputs are idle and a rising edge of `ref_i` is sampled without a rising edge of `div_i` in the same cycle, output 1 drives low (enable 1, value 0) from the next cycle.
- R4: Rising edges of both inputs sampled in the same cycle while the outputs are idle leave output 1 at high impedance.
- R5: While a drive is active, a rising edge of the lagging input returns output 1 to high impedance in the next cycle.
- R6: Further rising edges of the leading input do not extend or stack the request. A single edge of the lagging input clears it.
- R7: With `out2_mode_i` = 00, output 2 carries the same enable and value as output 1.
- R8: With `out2_mode_i` = 01, output 2 is high impedance.
- R9: With `out2_mode_i` = 10, output 2 drives `port_bit_i` with enable 1.
- R10: With `out2_mode_i` = 11 (reserved), output 2 is high impedance.
- R11: The setting of `out2_mode_i` has no effect on output 1.
- R12: The up request and the down request are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference frequency input |
| div_i | input | 1 | Programmable divider output |
| out2_mode_i | input | 2 | Output 2 mode: 00 comparator, 01 float, 10 port, 11 float |
| port_bit_i | input | 1 | Level driven on output 2 in port mode |
| out1_en_o | output | 1 | Output 1 drive enable |
| out1_val_o | output | 1 | Output 1 driven level |
| out2_en_o | output | 1 | Output 2 drive enable |
| out2_val_o | output | 1 | Output 2 driven level |

## Verification
The bench targets coincident edges. A design whose AND reset is missing or late would show a one-cycle drive pulse there, or get stuck driving. It repeats edges of the leading input before the lagging edge arrives; a design that counts edges would stay driving after the single clearing edge. It switches output 2 through every mode while a request is pending, to catch a multiplexer that leaks the port bit or the comparator into the wrong mode, or that disturbs output 1.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned N_SIG  = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_DIV = 1;

  typedef enum logic [MODE_W-1:0] {
    OUT2_PFD  = 2'b00,
    OUT2_HIZ  = 2'b01,
    OUT2_PORT = 2'b10,
    OUT2_RSVD = 2'b11
  } out2_mode_e;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic div_rise_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q, up_set, dn_set, clr;

  assign up_set = up_q | div_rise_i;
  assign dn_set = dn_q | ref_rise_i;
  // AND reset: both pending -> clear both in the same cycle
  assign clr    = up_set & dn_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set & ~clr;
      dn_q <= dn_set & ~clr;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/pfd_out_mux.sv
module pfd_out_mux
  import pfd_pkg::*;
(
  input  logic              up_i,
  input  logic              dn_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              port_bit_i,
  output logic              out1_en_o,
  output logic              out1_val_o,
  output logic              out2_en_o,
  output logic              out2_val_o
);
  logic cmp_en, cmp_val;

  assign cmp_en  = up_i | dn_i;
  assign cmp_val = up_i;

  assign out1_en_o  = cmp_en;
  assign out1_val_o = cmp_val;

  always_comb begin
    out2_en_o  = 1'b0;
    out2_val_o = 1'b0;
    unique case (out2_mode_e'(mode_i))
      OUT2_PFD: begin
        out2_en_o  = cmp_en;
        out2_val_o = cmp_val;
      end
      OUT2_PORT: begin
        out2_en_o  = 1'b1;
        out2_val_o = port_bit_i;
      end
      OUT2_HIZ, OUT2_RSVD: begin
        out2_en_o  = 1'b0;
        out2_val_o = 1'b0;
      end
      default: begin
        out2_en_o  = 1'b0;
        out2_val_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              div_i,
  input  logic [MODE_W-1:0] out2_mode_i,
  input  logic              port_bit_i,
  output logic              out1_en_o,
  output logic              out1_val_o,
  output logic              out2_en_o,
  output logic              out2_val_o
);
  logic [N_SIG-1:0] sig, rise;
  logic up, dn;

  assign sig[IDX_REF] = ref_i;
  assign sig[IDX_DIV] = div_i;

  pfd_edge_det #(.W(N_SIG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig),
    .rise_o (rise)
  );

  pfd_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (rise[IDX_REF]),
    .div_rise_i (rise[IDX_DIV]),
    .up_o       (up),
    .dn_o       (dn)
  );

  pfd_out_mux u_mux (
    .up_i       (up),
    .dn_i       (dn),
    .mode_i     (out2_mode_i),
    .port_bit_i (port_bit_i),
    .out1_en_o  (out1_en_o),
    .out1_val_o (out1_val_o),
    .out2_en_o  (out2_en_o),
    .out2_val_o (out2_val_o)
  );
endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_i,
  input logic       div_i,
  input logic [1:0] out2_mode_i,
  input logic       port_bit_i,
  input logic       out1_en_o,
  input logic       out1_val_o,
  input logic       out2_en_o,
  input logic       out2_val_o,
  input logic       up_i,
  input logic       dn_i
);
  AST_DIV_LEAD_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out1_en_o && $rose(div_i) && !$rose(ref_i)) |=> (out1_en_o && out1_val_o)); // R2
  AST_REF_LEAD_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out1_en_o && $rose(ref_i) && !$rose(div_i)) |=> (out1_en_o && !out1_val_o)); // R3
  AST_COINCIDENT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out1_en_o && $rose(ref_i) && $rose(div_i)) |=> !out1_en_o); // R4
  AST_LAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out1_en_o && out1_val_o && $rose(ref_i)) |=> !out1_en_o); // R5
  AST_OUT2_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out2_mode_i == 2'b00) |-> (out2_en_o == out1_en_o && (!out1_en_o || out2_val_o == out1_val_o))); // R7
  AST_OUT2_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out2_mode_i == 2'b01) |-> !out2_en_o); // R8
  AST_OUT2_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out2_mode_i == 2'b10) |-> (out2_en_o && out2_val_o == port_bit_i)); // R9
  AST_OUT2_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out2_mode_i == 2'b11) |-> !out2_en_o); // R10
  AST_UPDN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_i && dn_i)); // R12
endmodule

bind pfd_tristate pfd_tristate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_i       (ref_i),
  .div_i       (div_i),
  .out2_mode_i (out2_mode_i),
  .port_bit_i  (port_bit_i),
  .out1_en_o   (out1_en_o),
  .out1_val_o  (out1_val_o),
  .out2_en_o   (out2_en_o),
  .out2_val_o  (out2_val_o),
  .up_i        (up),
  .dn_i        (dn)
);

// File: tb/pfd_tristate_bench.sv
module pfd_tristate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_s = 1'b0, div_s = 1'b0, port_s = 1'b0;
  logic [1:0] mode_s = 2'b00;
  logic e1, v1, e2, v2;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic e1, v1, e2, v2;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pfd_tristate u_pfd_tristate (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .div_i(div_s),
    .out2_mode_i(mode_s), .port_bit_i(port_s),
    .out1_en_o(e1), .out1_val_o(v1), .out2_en_o(e2), .out2_val_o(v2)
  );

  // driver: apply inputs at negedge, push expected state after next posedge
  task automatic step(input logic r, input logic d, input logic [1:0] m, input logic p,
                      input logic xe1, input logic xv1, input logic xe2, input logic xv2,
                      input string tag);
    exp_t it;
    @(negedge clk);
    ref_s = r; div_s = d; mode_s = m; port_s = p;
    @(posedge clk);
    #1;
    it.e1 = xe1; it.v1 = xv1; it.e2 = xe2; it.v2 = xv2; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pop and compare
  initial begin
    exp_t it;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      n_run++;
      if (e1 !== it.e1 || (it.e1 && v1 !== it.v1) ||
          e2 !== it.e2 || (it.e2 && v2 !== it.v2)) begin
        n_fail++;
        $display("FAIL %s: got en1=%b v1=%b en2=%b v2=%b exp en1=%b v1=%b en2=%b v2=%b",
                 it.tag, e1, v1, e2, v2, it.e1, it.v1, it.e2, it.v2);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0,0,0,0, 0,0,0,0, "R1 reset idle");
    // div leads
    step(0,1,0,0, 1,1,1,1, "R2 div lead up");
    step(0,1,0,0, 1,1,1,1, "R2 hold up");
    step(0,0,0,0, 1,1,1,1, "R7 mirror up");
    step(1,0,0,0, 0,0,0,0, "R5 ref clears up");
    step(0,0,0,0, 0,0,0,0, "R5 idle");
    // ref leads
    step(1,0,0,0, 1,0,1,0, "R3 ref lead dn");
    step(1,1,0,0, 0,0,0,0, "R5 div clears dn");
    step(0,0,0,0, 0,0,0,0, "R5 idle2");
    // coincident
    step(1,1,0,0, 0,0,0,0, "R4 coincident");
    step(0,0,0,0, 0,0,0,0, "R4 after");
    // repeated leading edges
    step(0,1,0,0, 1,1,1,1, "R6 first div");
    step(0,0,0,0, 1,1,1,1, "R6 pending");
    step(0,1,0,0, 1,1,1,1, "R6 second div");
    step(0,0,0,0, 1,1,1,1, "R6 pending2");
    step(1,0,0,0, 0,0,0,0, "R6 single ref clears");
    step(0,0,0,0, 0,0,0,0, "R6 idle");
    // mode 01
    step(0,1,1,1, 1,1,0,0, "R8 float while up");
    step(1,0,1,1, 0,0,0,0, "R11 mode01 clear");
    step(0,0,1,1, 0,0,0,0, "R8 idle");
    // mode 10
    step(0,0,2,1, 0,0,1,1, "R9 port 1");
    step(0,0,2,0, 0,0,1,0, "R9 port 0");
    step(1,0,2,1, 1,0,1,1, "R11 dn under port mode");
    // mode 11
    step(0,1,3,1, 0,0,0,0, "R10 clear rsvd");
    step(0,0,3,0, 0,0,0,0, "R10 idle");
    step(1,0,3,1, 1,0,0,0, "R10 float while dn");
    step(0,0,0,0, 1,0,1,0, "R7 mirror dn");
    step(0,1,0,0, 0,0,0,0, "R12 clear to idle");
    wait (q.size() == 0);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule